// File: doc/BRIEF.md
# DRAM Self-Counted Refresh Scheduler

This block keeps a dynamic memory alive by running refresh cycles in which the column strobe is lowered ahead of the row strobe. In this kind of cycle the memory ignores the address bus and picks the next row from a counter of its own, so the scheduler drives only the two strobes. An interval timer, counting clock cycles, produces one refresh obligation per period. With the defaults at a 100 MHz clock that period is 1560 cycles, which spreads 512 refreshes over 8 ms. The timer starts only once memory initialisation has finished.

Obligations collect in a saturating pending counter. The access controller gets a request and answers with a grant once its current access is complete. While the controller holds a page open, a request is withheld. When the pending count reaches its limit, an urgent flag overrides the page hold. Once granted, the strobe sequencer pays back every pending refresh in one back-to-back burst for as long as the grant stays high. Between refreshes the column strobe stays low and only the row strobe is cycled.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `ras_n` and `cas_n` are 1, `ref_req` and `urgent` are 0, and `pend_cnt` is 0.
- R2: While `init_done` is 0 no obligation is created. `pend_cnt` first rises after `INTERVAL_CYC` rising clock edges with `init_done` high, counting the first such edge as one, and then rises once every `INTERVAL_CYC` edges.
- R3: `pend_cnt` never exceeds `MAX_PEND`. An expiry at the limit is dropped. `urgent` is 1 exactly when `pend_cnt` equals `MAX_PEND`.
- R4: When no refresh is under way, `ref_req` is 1 exactly when `pend_cnt` is above 0 and either `page_hold` is 0 or `urgent` is 1.
- R5: A refresh starts only on a clock edge where the request condition of R4 and `ref_gnt` are both 1. With no grant, the strobes stay at 1.
- R6: `cas_n` falls exactly `LEAD_CYC` cycles before `ras_n` falls.
- R7: Each `ras_n` low pulse lasts exactly `RAS_LOW_CYC` cycles, with `cas_n` at 0 throughout. `ras_n` stays high for at least `RAS_PRE_CYC` cycles between low pulses.
- R8: Each falling edge of `ras_n` takes one from `pend_cnt`. If an interval expires on that same edge, `pend_cnt` keeps its value, even at `MAX_PEND`.
- R9: If `ref_gnt` is 1 and `pend_cnt` is above 0 at the end of a RAS-low pulse, the next refresh follows after exactly `RAS_PRE_CYC` high cycles with `cas_n` held low. On the final precharge of a burst, `cas_n` is 1.
- R10: `ref_req` stays 1 from the start of a refresh until its final precharge ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Memory power-up sequence complete; enables the interval timer |
| page_hold | input | 1 | Access controller is keeping a page open |
| ref_gnt | input | 1 | Access controller has released the memory for refresh |
| ref_req | output | 1 | Refresh wanted or in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| urgent | output | 1 | Pending count is at its limit |
| pend_cnt | output | PEND_W | Refreshes owed |

## Verification
Two functions can meet on a single clock edge: an interval expiry, which adds a pending refresh, and a row-strobe fall, which consumes one. The bench keeps its own count of clock edges since `init_done` rose and asserts the grant so that the row strobe falls exactly on an expiry edge, with the count already at its limit. It then requires `pend_cnt` to hold its value on that edge. A decrement-only counter would show one less; a counter that saturated before decrementing would also lose the expiry. A second refresh, placed well away from any expiry, must lower the count by exactly one.

// File: rtl/cbr_pkg.sv
// Shared types for the refresh scheduler.
package cbr_pkg;
    // Phases of the strobe sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // strobes inactive
        SEQ_LEAD = 2'd1,   // column strobe low ahead of row strobe
        SEQ_RLOW = 2'd2,   // row strobe low
        SEQ_PRE  = 2'd3    // row precharge
    } seq_state_e;
endpackage

// File: rtl/cbr_interval_timer.sv
// Interval timer: emits a one-cycle tick every INTERVAL_CYC clocks.
// Assumes init_done stays high once set; the count restarts while it is low.
module cbr_interval_timer #(
    parameter int INTERVAL_CYC = 1560,
    localparam int TMR_W = $clog2(INTERVAL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done,
    output logic tick
);
    logic [TMR_W-1:0] tmr_q;

    assign tick = init_done && (tmr_q == TMR_W'(INTERVAL_CYC - 1));

    // Free-running count, held at zero until initialisation completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !init_done) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/cbr_pending_ctr.sv
// Pending counter: adds one per tick, removes one per refresh issued,
// saturates at MAX_PEND. Assumes consume is never raised at zero.
module cbr_pending_ctr #(
    parameter int MAX_PEND = 8,
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              consume,
    output logic [PEND_W-1:0] pend_q,
    output logic              full
);
    localparam logic [PEND_W-1:0] PEND_FULL = PEND_W'(MAX_PEND);

    assign full = (pend_q == PEND_FULL);

    // Net update: a tick and a consume in one cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            case ({tick, consume})
                2'b10:   if (!full) pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end
endmodule

// File: rtl/cbr_strobe_seq.sv
// Strobe sequencer: runs column-first refresh cycles and chains them into
// a burst while the grant holds and refreshes remain. Each phase length is
// a parameter of at least one cycle. Strobes are decoded from the state.
module cbr_strobe_seq
    import cbr_pkg::*;
#(
    parameter int LEAD_CYC    = 1,
    parameter int RAS_LOW_CYC = 8,
    parameter int RAS_PRE_CYC = 6,
    localparam int LONGEST = (LEAD_CYC > RAS_LOW_CYC)
                           ? ((LEAD_CYC > RAS_PRE_CYC) ? LEAD_CYC : RAS_PRE_CYC)
                           : ((RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC),
    localparam int CNT_W = $clog2(LONGEST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,      // refresh may be requested
    input  logic ref_gnt,
    input  logic pend_nz,
    output logic busy,
    output logic ras_fall,  // row strobe falls at the next edge
    output logic ras_n,
    output logic cas_n
);
    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cont_q;
    logic             phase_end;

    // End of the current phase from the per-state length.
    always_comb begin
        case (st_q)
            SEQ_LEAD: phase_end = (cnt_q == CNT_W'(LEAD_CYC - 1));
            SEQ_RLOW: phase_end = (cnt_q == CNT_W'(RAS_LOW_CYC - 1));
            SEQ_PRE:  phase_end = (cnt_q == CNT_W'(RAS_PRE_CYC - 1));
            default:  phase_end = 1'b0;
        endcase
    end

    assign ras_fall = phase_end && ((st_q == SEQ_LEAD) ||
                      ((st_q == SEQ_PRE) && cont_q && ref_gnt && pend_nz));
    assign busy  = (st_q != SEQ_IDLE);
    assign ras_n = (st_q != SEQ_RLOW);
    assign cas_n = !((st_q == SEQ_LEAD) || (st_q == SEQ_RLOW) ||
                     ((st_q == SEQ_PRE) && cont_q));

    // Phase progression and burst decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            cnt_q  <= '0;
            cont_q <= 1'b0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (want && ref_gnt) st_q <= SEQ_LEAD;
                end
                SEQ_LEAD: begin
                    if (phase_end) begin
                        st_q  <= SEQ_RLOW;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_RLOW: begin
                    if (phase_end) begin
                        st_q   <= SEQ_PRE;
                        cnt_q  <= '0;
                        cont_q <= pend_nz && ref_gnt;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (phase_end) begin
                        cnt_q <= '0;
                        st_q  <= ras_fall ? SEQ_RLOW : SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cbr_refresh_sched.sv
// Refresh scheduler top: interval timer, pending counter and strobe
// sequencer. Assumes the access controller keeps ref_gnt high only while
// it leaves the memory alone. The memory supplies the row address itself.
module cbr_refresh_sched #(
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8,
    parameter int LEAD_CYC     = 1,
    parameter int RAS_LOW_CYC  = 8,
    parameter int RAS_PRE_CYC  = 6,
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              page_hold,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ras_n,
    output logic              cas_n,
    output logic              urgent,
    output logic [PEND_W-1:0] pend_cnt
);
    logic tick;
    logic ras_fall;
    logic busy;
    logic want;

    // Request gating: page hold defers unless the backlog is full.
    assign want    = (pend_cnt != '0) && (!page_hold || urgent);
    assign ref_req = busy || want;

    cbr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .tick      (tick)
    );

    cbr_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .consume (ras_fall),
        .pend_q  (pend_cnt),
        .full    (urgent)
    );

    cbr_strobe_seq #(
        .LEAD_CYC    (LEAD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_PRE_CYC (RAS_PRE_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .ref_gnt  (ref_gnt),
        .pend_nz  (pend_cnt != '0),
        .busy     (busy),
        .ras_fall (ras_fall),
        .ras_n    (ras_n),
        .cas_n    (cas_n)
    );
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
// Property checker for the refresh scheduler, attached through bind.
// Pulse widths are measured with counters, not deep $past.
module cbr_refresh_sched_chk #(
    parameter int MAX_PEND    = 8,
    parameter int RAS_LOW_CYC = 8,
    parameter int RAS_PRE_CYC = 6,
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ras_n,
    input logic              cas_n,
    input logic              urgent,
    input logic [PEND_W-1:0] pend_cnt
);
    logic [15:0] low_run;
    logic [15:0] high_run;

    // Length of the current row-strobe low and high runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '1;
        end else begin
            low_run  <= ras_n ? '0 : low_run + 1'b1;
            high_run <= !ras_n ? '0 : ((high_run == '1) ? high_run : high_run + 1'b1);
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ras_n && cas_n && !ref_req && !urgent && pend_cnt == '0));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_W'(MAX_PEND));
    p_urgent_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        urgent == (pend_cnt == PEND_W'(MAX_PEND)));
    p_start_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(ref_gnt) && $past(ref_req));
    p_cas_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !$past(cas_n));
    p_cas_low_under_ras_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);
    p_ras_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> low_run == 16'(RAS_LOW_CYC));
    p_ras_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> high_run >= 16'(RAS_PRE_CYC));
    p_pend_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == $past(pend_cnt)) || (pend_cnt == $past(pend_cnt) + 1'b1) ||
        (pend_cnt + 1'b1 == $past(pend_cnt)));
    p_req_while_strobing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> ref_req);
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
    .MAX_PEND    (MAX_PEND),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .urgent   (urgent),
    .pend_cnt (pend_cnt)
);

// File: tb/test_cbr_refresh_sched.sv
module test_cbr_refresh_sched;
    localparam int INTERVAL = 100;
    localparam int MAXP     = 4;
    localparam int LEAD     = 2;
    localparam int RLOW     = 4;
    localparam int RPRE     = 3;
    localparam int PW       = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_done = 1'b0;
    logic page_hold = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ras_n, cas_n, urgent;
    logic [PW-1:0] pend_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // Edges seen with init_done high, counted independently of the design.
    always @(posedge clk) begin
        if (!rst_n || !init_done) cyc <= 0;
        else cyc <= cyc + 1;
    end

    cbr_refresh_sched #(
        .INTERVAL_CYC (INTERVAL),
        .MAX_PEND     (MAXP),
        .LEAD_CYC     (LEAD),
        .RAS_LOW_CYC  (RLOW),
        .RAS_PRE_CYC  (RPRE)
    ) i_cbr_refresh_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .page_hold (page_hold),
        .ref_gnt   (ref_gnt),
        .ref_req   (ref_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .urgent    (urgent),
        .pend_cnt  (pend_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_phase(input int p);
        @(negedge clk);
        while ((cyc % INTERVAL) != p) @(negedge clk);
    endtask

    // Count edges until pend_cnt equals target.
    task automatic edges_until(input int target, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (int'(pend_cnt) != target && n < 1000);
    endtask

    // Sample ncyc negedges after a start edge and compare the strobes and
    // request with the pattern for nf chained refreshes.
    task automatic trace(input int nf, input int ncyc, input bit drop_gnt,
                         input bit req_after, output int pend_fall);
        int bad_ras = 0, bad_cas = 0, bad_req = 0;
        int first_cas = -1, first_ras = -1;
        pend_fall = -1;
        for (int i = 0; i < ncyc; i++) begin
            bit exp_ras_low, exp_cas_low, exp_req;
            @(negedge clk);
            if (i == 0 && drop_gnt) ref_gnt = 1'b0;
            exp_ras_low = (i >= LEAD) && ((i - LEAD) / (RLOW + RPRE) < nf) &&
                          ((i - LEAD) % (RLOW + RPRE) < RLOW);
            exp_cas_low = (i < LEAD + nf * RLOW + (nf - 1) * RPRE);
            exp_req     = (i < LEAD + nf * (RLOW + RPRE)) ? 1'b1 : req_after;
            if (ras_n != !exp_ras_low) bad_ras++;
            if (cas_n != !exp_cas_low) bad_cas++;
            if (ref_req != exp_req) bad_req++;
            if (first_cas < 0 && !cas_n) first_cas = i;
            if (first_ras < 0 && !ras_n) first_ras = i;
            if (i == LEAD) pend_fall = int'(pend_cnt);
        end
        chk(first_ras - first_cas == LEAD, "R6 cas-to-ras lead", first_ras - first_cas, LEAD);
        chk(bad_ras == 0, "R7 ras_n pulse pattern mismatches", bad_ras, 0);
        chk(bad_cas == 0, "R9 cas_n burst pattern mismatches", bad_cas, 0);
        chk(bad_req == 0, "R10 ref_req window mismatches", bad_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, pf, bad;
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n && !ref_req && !urgent && pend_cnt == 0,
            "R1 outputs in reset", {ras_n, cas_n, ref_req, urgent}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !ref_req && pend_cnt == 0, "R1 after release",
            int'(pend_cnt), 0);

        // R2: nothing accrues before init_done.
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (pend_cnt != 0 || ref_req) bad++;
        end
        chk(bad == 0, "R2 idle before init", bad, 0);

        // R2: first obligation after exactly INTERVAL edges.
        init_done = 1'b1;
        edges_until(1, n);
        chk(n == INTERVAL, "R2 first interval", n, INTERVAL);
        chk(ref_req == 1'b1, "R4 request with pending", ref_req, 1);
        chk(ras_n && cas_n, "R5 no strobes without grant", {ras_n, cas_n}, 3);

        // R2/R3: steady interval and urgent flag at each level.
        for (int k = 2; k <= MAXP; k++) begin
            edges_until(k, n);
            chk(n == INTERVAL, "R2 repeat interval", n, INTERVAL);
            chk(urgent == (k == MAXP), "R3 urgent at level", urgent, k == MAXP);
        end
        bad = 0;
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            @(negedge clk);
            if (pend_cnt != MAXP || !urgent) bad++;
        end
        chk(bad == 0, "R3 saturation held", bad, 0);

        // R8: row strobe falls on an expiry edge while full, count holds.
        wait_phase(INTERVAL - LEAD - 1);
        ref_gnt = 1'b1;
        trace(1, 16, 1'b1, 1'b1, pf);
        chk(pf == MAXP, "R8 expiry coincides with ras fall", pf, MAXP);
        chk(pend_cnt == MAXP, "R8 count after coincident refresh", int'(pend_cnt), MAXP);

        // R8: a lone refresh away from expiry takes exactly one.
        wait_phase(10);
        ref_gnt = 1'b1;
        trace(1, 16, 1'b1, 1'b1, pf);
        chk(pend_cnt == MAXP - 1, "R8 single decrement", int'(pend_cnt), MAXP - 1);

        // R9/R10: full backlog repaid in one burst.
        edges_until(MAXP, n);
        wait_phase(5);
        ref_gnt = 1'b1;
        trace(MAXP, 40, 1'b0, 1'b0, pf);
        chk(pend_cnt == 0, "R9 burst repays all", int'(pend_cnt), 0);
        ref_gnt = 1'b0;

        // R4: page hold defers requests until urgent.
        @(negedge clk);
        page_hold = 1'b1;
        ref_gnt   = 1'b1;
        bad = 0;
        n = 0;
        while (pend_cnt != MAXP && n < 1000) begin
            @(negedge clk);
            n++;
            if (pend_cnt != MAXP && (ref_req || !ras_n || !cas_n)) bad++;
        end
        chk(bad == 0, "R4 hold suppresses request", bad, 0);
        chk(urgent && ref_req, "R4 urgent overrides hold", {urgent, ref_req}, 3);
        chk(cas_n == 1'b1, "R5 start waits for edge", cas_n, 1);
        trace(MAXP, 40, 1'b0, 1'b0, pf);
        chk(pend_cnt == 0, "R9 urgent burst repays all", int'(pend_cnt), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule